// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

The core executes one 32-bit instruction per clock. In a single cycle it fetches the word at the program counter from an external instruction memory, decodes it, reads up to two source registers and runs the ALU. Where the instruction needs it, the core also reads or writes an external data memory. On the next rising edge it updates the program counter, the destination register and the data memory together. Both memory ports are combinational on the read side. The data memory takes its write on the same edge that retires the store.

Control is a purely combinational decode of the opcode, funct3 and instruction bit 30. It selects the immediate layout, the second ALU operand, the ALU function, the write-back source, the register and memory write enables, and the next-PC source. The supported instructions are:

- register-register and register-immediate arithmetic and logic;
- word load and word store;
- six conditional branches;
- a PC-relative jump-and-link and a register-indirect jump-and-link.

Top module: `scyc_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0. After release, execution starts at address 0 and all 32 registers read as 0.
- R2: Opcode 0110011 performs rd = rs1 op rs2. funct3 selects the operation: 000 add (sub when bit 30 is set), 001 shift left, 010 signed less-than, 011 unsigned less-than, 100 xor, 101 logical right shift (arithmetic when bit 30 is set), 110 or, 111 and. Shifts use rs2[4:0].
- R3: Opcode 0010011 uses the same funct3 table with the sign-extended immediate in bits 31:20 as the second operand. Bit 30 selects the arithmetic right shift only for funct3 101, and for every other funct3 it is an ordinary immediate bit.
- R4: Opcode 0000011 (funct3 010) drives `dmem_addr` = rs1 + sign-extended bits 31:20 and writes `dmem_rdata` to rd.
- R5: Opcode 0100011 (funct3 010) drives `dmem_addr` = rs1 + the sign-extended immediate {bits 31:25, bits 11:7} and `dmem_wdata` = rs2. It asserts `dmem_we` and writes no register. No other opcode asserts `dmem_we`.
- R6: Opcode 1100011 compares rs1 with rs2. funct3 000 branches on equal, 001 on not equal, 100 on signed less, 101 on signed greater-or-equal, 110 on unsigned less and 111 on unsigned greater-or-equal. A taken branch moves to PC + {bit31, bit7, bits30:25, bits11:8, 0}, sign-extended, and a branch not taken moves to PC + 4. No register is written.
- R7: Opcode 1101111 writes PC + 4 to rd and moves to PC + {bit31, bits19:12, bit20, bits30:21, 0}, sign-extended.
- R8: Opcode 1100111 writes PC + 4 to rd and moves to (rs1 + sign-extended bits 31:20) with bit 0 cleared.
- R9: Register x0 reads as 0, and every write to it is discarded.
- R10: Any other opcode writes no register, does not assert `dmem_we` and advances the PC by 4.
- R11: All state changes take effect on one edge. An instruction whose rd equals a source uses the old source value, and the next instruction sees the new value.
- R12: `imem_addr` is the PC. Arithmetic, load and store instructions advance it by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, combinational |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, taken by the memory on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, combinational |

## Verification
In one cycle the register file serves a read and takes a write-back to the same register. The bench provokes this with an increment of the register just loaded and with an indirect jump whose link register is also its base. A correct core uses the old value as the operand, and the following store shows the new value.

A second collision involves branches, whose rd-position bits carry immediate bits that point at a live register. Stores whose displacement low bits also name a live register provoke the same case. Those registers are stored again afterwards, and any value that changed shows a false write-back that landed alongside the PC update.

// File: rtl/scyc_pkg.sv
package scyc_pkg;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_IMM    = 7'b0010011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JUMP   = 7'b1101111;
    localparam logic [6:0] OPC_JREG   = 7'b1100111;

    typedef enum logic [1:0] {IMM_I, IMM_S, IMM_B, IMM_J} imm_kind_e;
    typedef enum logic       {OPB_REG, OPB_IMM} opb_e;
    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
    } alu_fn_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_e;
    typedef enum logic [1:0] {NPC_SEQ, NPC_BR, NPC_JUMP, NPC_JREG} npc_e;

    typedef struct packed {
        imm_kind_e imm;
        opb_e      opb;
        alu_fn_e   fn;
        logic      mem_wr;
        logic      rf_wen;
        wb_e       wb;
        npc_e      npc;
    } ctrl_t;

    function automatic alu_fn_e alu_fn_of(logic [2:0] f3, logic alt);
        alu_fn_e r;
        case (f3)
            3'b000:  r = alt ? ALU_SUB : ALU_ADD;
            3'b001:  r = ALU_SLL;
            3'b010:  r = ALU_SLT;
            3'b011:  r = ALU_SLTU;
            3'b100:  r = ALU_XOR;
            3'b101:  r = alt ? ALU_SRA : ALU_SRL;
            3'b110:  r = ALU_OR;
            default: r = ALU_AND;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/scyc_decode.sv
module scyc_decode
    import scyc_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       alt_bit,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl.imm    = IMM_I;
        ctrl.opb    = OPB_REG;
        ctrl.fn     = ALU_ADD;
        ctrl.mem_wr = 1'b0;
        ctrl.rf_wen = 1'b0;
        ctrl.wb     = WB_ALU;
        ctrl.npc    = NPC_SEQ;
        case (opcode)
            OPC_REG: begin
                ctrl.fn     = alu_fn_of(funct3, alt_bit);
                ctrl.rf_wen = 1'b1;
            end
            OPC_IMM: begin
                ctrl.opb    = OPB_IMM;
                ctrl.fn     = alu_fn_of(funct3, alt_bit && (funct3 == 3'b101));
                ctrl.rf_wen = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.opb    = OPB_IMM;
                ctrl.rf_wen = 1'b1;
                ctrl.wb     = WB_MEM;
            end
            OPC_STORE: begin
                ctrl.imm    = IMM_S;
                ctrl.opb    = OPB_IMM;
                ctrl.mem_wr = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl.imm = IMM_B;
                ctrl.npc = NPC_BR;
            end
            OPC_JUMP: begin
                ctrl.imm    = IMM_J;
                ctrl.rf_wen = 1'b1;
                ctrl.wb     = WB_LINK;
                ctrl.npc    = NPC_JUMP;
            end
            OPC_JREG: begin
                ctrl.opb    = OPB_IMM;
                ctrl.rf_wen = 1'b1;
                ctrl.wb     = WB_LINK;
                ctrl.npc    = NPC_JREG;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scyc_immgen.sv
module scyc_immgen
    import scyc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:7]     ins,
    input  imm_kind_e       kind,
    output logic [XLEN-1:0] imm
);

    always_comb begin
        case (kind)
            IMM_S:   imm = {{(XLEN-12){ins[31]}}, ins[31:25], ins[11:7]};
            IMM_B:   imm = {{(XLEN-13){ins[31]}}, ins[31], ins[7], ins[30:25], ins[11:8], 1'b0};
            IMM_J:   imm = {{(XLEN-21){ins[31]}}, ins[31], ins[19:12], ins[20], ins[30:21], 1'b0};
            default: imm = {{(XLEN-12){ins[31]}}, ins[31:20]};
        endcase
    end

endmodule

// File: rtl/scyc_alu.sv
module scyc_alu
    import scyc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        case (fn)
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << shamt;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, a < b};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = $unsigned($signed(a) >>> shamt);
            ALU_OR:   y = a | b;
            ALU_AND:  y = a & b;
            default:  y = a + b;
        endcase
    end

endmodule

// File: rtl/scyc_brcond.sv
module scyc_brcond #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      funct3,
    output logic            take
);

    logic eq, lt, ltu;
    assign eq  = (a == b);
    assign lt  = ($signed(a) < $signed(b));
    assign ltu = (a < b);

    always_comb begin
        case (funct3)
            3'b000:  take = eq;
            3'b001:  take = !eq;
            3'b100:  take = lt;
            3'b101:  take = !lt;
            3'b110:  take = ltu;
            3'b111:  take = !ltu;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/scyc_regfile.sv
module scyc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] ra1,
    input  logic [$clog2(NREG)-1:0] ra2,
    input  logic [$clog2(NREG)-1:0] wa,
    input  logic                    we,
    input  logic [XLEN-1:0]         wd,
    output logic [XLEN-1:0]         rd1,
    output logic [XLEN-1:0]         rd2
);

    localparam int AW = $clog2(NREG);

    logic [XLEN-1:0] regs_q [NREG];
    logic [XLEN-1:0] regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = regs_q[ra1];
    assign rd2 = regs_q[ra2];

    // R9: register zero never changes away from 0
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);

    // R11: an enabled write is visible from the following cycle
    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (wa != AW'(0))) |=> (regs_q[$past(wa)] == $past(wd)));

endmodule

// File: rtl/scyc_core.sv
module scyc_core
    import scyc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [31:0]     imem_rdata,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int AW = $clog2(NREG);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [6:0]      opcode;
    logic [2:0]      funct3;
    logic [AW-1:0]   rs1_idx, rs2_idx, rd_idx;
    ctrl_t           ctrl;
    logic [XLEN-1:0] imm, src1, src2, alu_b, alu_y, wb_data;
    logic [XLEN-1:0] pc_seq;
    logic            br_take;

    assign opcode  = imem_rdata[6:0];
    assign funct3  = imem_rdata[14:12];
    assign rd_idx  = imem_rdata[7 +: AW];
    assign rs1_idx = imem_rdata[15 +: AW];
    assign rs2_idx = imem_rdata[20 +: AW];

    scyc_decode u_dec (
        .opcode  (opcode),
        .funct3  (funct3),
        .alt_bit (imem_rdata[30]),
        .ctrl    (ctrl)
    );

    scyc_immgen #(.XLEN(XLEN)) u_imm (
        .ins  (imem_rdata[31:7]),
        .kind (ctrl.imm),
        .imm  (imm)
    );

    scyc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs1_idx),
        .ra2   (rs2_idx),
        .wa    (rd_idx),
        .we    (ctrl.rf_wen),
        .wd    (wb_data),
        .rd1   (src1),
        .rd2   (src2)
    );

    assign alu_b = (ctrl.opb == OPB_IMM) ? imm : src2;

    scyc_alu #(.XLEN(XLEN)) u_alu (
        .a  (src1),
        .b  (alu_b),
        .fn (ctrl.fn),
        .y  (alu_y)
    );

    scyc_brcond #(.XLEN(XLEN)) u_br (
        .a      (src1),
        .b      (src2),
        .funct3 (funct3),
        .take   (br_take)
    );

    assign pc_seq = st_q.pc + XLEN'(4);

    always_comb begin
        case (ctrl.wb)
            WB_MEM:  wb_data = dmem_rdata;
            WB_LINK: wb_data = pc_seq;
            default: wb_data = alu_y;
        endcase
    end

    always_comb begin
        st_d = st_q;
        case (ctrl.npc)
            NPC_BR:   st_d.pc = br_take ? (st_q.pc + imm) : pc_seq;
            NPC_JUMP: st_d.pc = st_q.pc + imm;
            NPC_JREG: st_d.pc = alu_y & ~XLEN'(1);
            default:  st_d.pc = pc_seq;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc <= XLEN'(RESET_PC);
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = src2;
    assign dmem_we    = ctrl.mem_wr && rst_n;

    logic known_op, straight_op;
    assign known_op = (opcode == OPC_REG) || (opcode == OPC_IMM) ||
                      (opcode == OPC_LOAD) || (opcode == OPC_STORE) ||
                      (opcode == OPC_BRANCH) || (opcode == OPC_JUMP) ||
                      (opcode == OPC_JREG);
    assign straight_op = (opcode == OPC_REG) || (opcode == OPC_IMM) ||
                         (opcode == OPC_LOAD) || (opcode == OPC_STORE);

    // R5: only a store instruction at the port may raise the write strobe
    a_r5_we_only_store: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (opcode == OPC_STORE));

    // R6: branches and stores leave the register file alone
    a_r6_no_wb_branch_store: assert property (@(posedge clk) disable iff (!rst_n)
        ((opcode == OPC_BRANCH) || (opcode == OPC_STORE)) |-> !ctrl.rf_wen);

    // R10: unknown opcodes have no side effect
    a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |-> (!ctrl.rf_wen && !dmem_we));

    // R10: unknown opcodes step the PC by 4
    a_r10_unknown_step: assert property (@(posedge clk) disable iff (!rst_n)
        !known_op |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

    // R12: straight-line instructions step the PC by 4
    a_r12_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        straight_op |=> (imem_addr == $past(imem_addr) + XLEN'(4)));

endmodule

// File: tb/scyc_core_test.sv
module scyc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_rdata;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    always #2 clk = ~clk;

    logic [31:0] imem [128];
    logic [31:0] dmem [256];

    assign imem_rdata = imem[imem_addr[8:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) begin
        if (rst_n && dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
    end

    scyc_core uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int wp     = 0;

    logic [31:0] exp_a [$];
    logic [31:0] exp_d [$];
    string       exp_t [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    // ---------------- encoders ----------------
    function automatic logic [31:0] e_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction
    function automatic logic [31:0] e_i(input logic [11:0] im, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
        return {im, rs1, f3, rd, op};
    endfunction
    function automatic logic [31:0] e_s(input logic [11:0] im, input logic [4:0] rs2,
                                        input logic [4:0] rs1);
        return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
    endfunction
    function automatic logic [31:0] e_b(input logic [12:0] im, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3);
        return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
    endfunction
    function automatic logic [31:0] e_j(input logic [20:0] im, input logic [4:0] rd);
        return {im[20], im[10:1], im[11], im[19:12], rd, 7'b1101111};
    endfunction

    task automatic put(input logic [31:0] w);
        imem[wp] = w;
        wp++;
    endtask

    // driver side of the scoreboard: each store the program should make
    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_a.push_back(a);
        exp_d.push_back(d);
        exp_t.push_back(tag);
    endtask

    // store rs2 to x10 + off and record the expected word
    task automatic st(input logic [4:0] rs, input int off, input logic [31:0] d, input string tag);
        put(e_s(12'(off), rs, 5'd10));
        expect_store(32'h100 + 32'(off), d, tag);
    endtask

    function automatic logic [31:0] addi(input logic [4:0] rd, input logic [4:0] rs, input int im);
        return e_i(12'(im), rs, 3'b000, rd, 7'b0010011);
    endfunction

    // ---------------- monitor ----------------
    bit run_mon = 1'b0;

    always @(negedge clk) begin
        if (run_mon && dmem_we) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R5", "unexpected store addr", dmem_addr, 32'hx);
            end else begin
                logic [31:0] ea, ed;
                string et;
                ea = exp_a.pop_front();
                ed = exp_d.pop_front();
                et = exp_t.pop_front();
                check(dmem_addr == ea, et, "store address", dmem_addr, ea);
                check(dmem_wdata == ed, et, "store data", dmem_wdata, ed);
            end
        end
    end

    logic [31:0] halt_pc;

    initial begin
        for (int k = 0; k < 128; k++) imem[k] = 32'h0;
        for (int k = 0; k < 256; k++) dmem[k] = 32'h0;
        dmem[32'h80 >> 2] = 32'hDEADBEEF;

        // setup
        put(addi(5'd1, 5'd0, 5));
        put(addi(5'd2, 5'd0, -3));
        put(addi(5'd10, 5'd0, 32'h100));
        // R2 register ops
        put(e_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd3));
        st(5'd3, 0, 32'h2, "R2");
        put(e_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd4));
        st(5'd4, 4, 32'h8, "R2");
        put(e_r(7'h00, 5'd1, 5'd2, 3'b010, 5'd5));
        put(e_r(7'h00, 5'd1, 5'd2, 3'b011, 5'd6));
        st(5'd5, 8, 32'h1, "R2");
        st(5'd6, 12, 32'h0, "R2");
        put(e_r(7'h20, 5'd1, 5'd2, 3'b101, 5'd7));
        put(e_r(7'h00, 5'd1, 5'd2, 3'b101, 5'd8));
        put(e_r(7'h00, 5'd1, 5'd1, 3'b001, 5'd9));
        st(5'd7, 16, 32'hFFFF_FFFF, "R2");
        st(5'd8, 20, 32'h07FF_FFFF, "R2");
        st(5'd9, 24, 32'h0000_00A0, "R2");
        put(e_r(7'h00, 5'd2, 5'd1, 3'b100, 5'd11));
        put(e_r(7'h00, 5'd2, 5'd1, 3'b110, 5'd12));
        put(e_r(7'h00, 5'd2, 5'd1, 3'b111, 5'd13));
        st(5'd11, 28, 32'hFFFF_FFF8, "R2");
        st(5'd12, 32, 32'hFFFF_FFFD, "R2");
        st(5'd13, 36, 32'h5, "R2");
        // R3 immediate ops
        put(e_i(12'hFFE, 5'd2, 3'b010, 5'd14, 7'b0010011));
        put(e_i(12'hFFF, 5'd1, 3'b011, 5'd15, 7'b0010011));
        put(e_i(12'hFFF, 5'd1, 3'b100, 5'd16, 7'b0010011));
        put(e_i(12'h401, 5'd2, 3'b101, 5'd17, 7'b0010011));
        put(e_i(12'h400, 5'd1, 3'b000, 5'd18, 7'b0010011));
        st(5'd14, 40, 32'h1, "R3");
        st(5'd15, 44, 32'h1, "R3");
        st(5'd16, 48, 32'hFFFF_FFFA, "R3");
        st(5'd17, 52, 32'hFFFF_FFFE, "R3");
        st(5'd18, 56, 32'h405, "R3");
        // R9 zero register
        put(addi(5'd0, 5'd1, 7));
        st(5'd0, 60, 32'h0, "R9");
        // R4 load, R11 read and write same register
        put(e_i(12'hF80, 5'd10, 3'b010, 5'd19, 7'b0000011));
        put(addi(5'd19, 5'd19, 1));
        st(5'd19, 64, 32'hDEAD_BEF0, "R11");
        put(e_s(12'hFFC, 5'd1, 5'd10));
        expect_store(32'h0FC, 32'h5, "R5");
        put(e_i(12'h000, 5'd10, 3'b010, 5'd20, 7'b0000011));
        st(5'd20, 68, 32'h2, "R4");
        // R6 branches: each not-taken one sets a bit in x22
        begin
            logic [2:0] f3s [12] = '{3'b000, 3'b000, 3'b001, 3'b001, 3'b100, 3'b100,
                                     3'b101, 3'b101, 3'b110, 3'b110, 3'b111, 3'b111};
            logic [4:0] ra [12] = '{5'd1, 5'd1, 5'd1, 5'd1, 5'd2, 5'd1,
                                    5'd1, 5'd2, 5'd1, 5'd2, 5'd2, 5'd1};
            logic [4:0] rb [12] = '{5'd1, 5'd2, 5'd2, 5'd1, 5'd1, 5'd2,
                                    5'd2, 5'd1, 5'd2, 5'd1, 5'd1, 5'd2};
            for (int k = 0; k < 12; k++) begin
                put(e_b(13'd8, rb[k], ra[k], f3s[k]));
                put(e_i(12'(1 << k), 5'd22, 3'b110, 5'd22, 7'b0010011));
            end
        end
        st(5'd22, 72, 32'hFFFF_FAAA, "R6");
        // backward branch loop
        put(addi(5'd24, 5'd0, 0));
        put(addi(5'd25, 5'd0, 3));
        put(addi(5'd24, 5'd24, 1));
        put(e_b(-13'sd4, 5'd25, 5'd24, 3'b001));
        st(5'd24, 76, 32'h3, "R6");
        // R7 jump and link over two poison stores
        begin
            logic [31:0] link;
            link = 32'(wp * 4 + 4);
            put(e_j(21'd12, 5'd26));
            put(e_s(12'd80, 5'd1, 5'd10));
            put(e_s(12'd80, 5'd1, 5'd10));
            st(5'd26, 84, link, "R7");
        end
        // R8 indirect jump, rd equals rs1, bit 0 of target cleared
        begin
            logic [31:0] at, land;
            at   = 32'(wp * 4 + 4);
            land = at + 32'd20;
            put(addi(5'd27, 5'd0, int'(land) - 4));
            put(e_i(12'd5, 5'd27, 3'b000, 5'd27, 7'b1100111));
            for (int k = 0; k < 4; k++) put(e_s(12'd80, 5'd1, 5'd10));
            st(5'd27, 88, at + 32'd4, "R8");
        end
        // R10 unknown opcode with rd = 31
        put(32'hFFFF_FFFF);
        st(5'd31, 92, 32'h0, "R10");
        st(5'd28, 96, 32'h0, "R5");
        st(5'd8, 100, 32'h07FF_FFFF, "R6");
        halt_pc = 32'(wp * 4);
        put(e_j(21'd0, 5'd0));

        // R1 reset state
        repeat (3) @(negedge clk);
        check(imem_addr == 32'h0, "R1", "pc in reset", imem_addr, 32'h0);
        check(dmem_we == 1'b0, "R1", "write strobe in reset", {31'h0, dmem_we}, 32'h0);
        rst_n   = 1'b1;
        run_mon = 1'b1;
        #1;
        check(imem_addr == 32'h0, "R1", "first fetch", imem_addr, 32'h0);
        @(negedge clk);
        check(imem_addr == 32'h4, "R12", "pc step", imem_addr, 32'h4);
        @(negedge clk);
        check(imem_addr == 32'h8, "R12", "pc step", imem_addr, 32'h8);

        // watchdog: the program must drain the expected list
        for (int c = 0; c < 2000 && exp_a.size() != 0; c++) @(negedge clk);
        check(exp_a.size() == 0, "R6", "stores outstanding at timeout",
              32'(exp_a.size()), 32'h0);
        repeat (4) @(negedge clk);
        check(imem_addr == halt_pc, "R7", "self loop pc", imem_addr, halt_pc);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule